// File: doc/BRIEF.md
# Even-Parity Asynchronous Serial Port

This block is a full-duplex asynchronous serial port. It connects a front-end controller to a remote supervisory host over two logic-level wires, one for receive and one for transmit. Every character on the line has four parts, in this order: a low start bit, eight data bits sent least-significant bit first, an even parity bit, and a high stop bit. The nominal line rate is 115,200 baud. A two-bit rate-select input, driven by configuration switches, can also select 57,600, 19,200 or 9,600 baud.

A single baud generator divides the system clock to sixteen times the selected rate, and both directions share it. The receiver passes the line through a two-flop synchronizer. It finds the falling edge of a start bit and confirms that start bit at its midpoint, then samples every later bit at mid-bit. Each character it receives comes out as a one-cycle valid pulse, together with the byte, a parity-error flag and a framing-error flag, so that the controller can report bad characters upstream. The transmitter takes a byte on a ready/valid handshake and frames it on the line. When it has nothing to send, it holds the line high.

Top module: `ser8e1_port`

## Requirements
- R1: After reset, `txd` is high, `txReady` is high and `rxValid` is low.
- R2: An accepted byte leaves on `txd` as eleven bit cells of 16 ticks each: start = 0, data bits 0 to 7 in that order, parity = XOR of the eight data bits (even parity), stop = 1. The line is high whenever no frame is being sent.
- R3: `rateSel` picks the baud rate: 0 = 9600, 1 = 19200, 2 = 57600, 3 = 115200. The tick divisor is round(CLK_HZ / (16 * baud)), with a minimum of 1. One bit therefore lasts 16 times the divisor, in clock cycles.
- R4: `txReady` is high only while the transmitter is idle. It goes low in the cycle after a handshake and stays low for the whole frame. It rises again once the stop bit has finished.
- R5: A well-formed character on `rxd` produces exactly one `rxValid` pulse, one cycle wide. `rxData` carries the eight received bits with the first bit in bit 0.
- R6: `rxParErr` is set with `rxValid` when the eight data bits and the received parity bit hold an odd number of ones. It is clear when they hold an even number.
- R7: `rxFrameErr` is set with `rxValid` when the stop bit samples low. The byte is still delivered. No new start bit is searched for until `rxd` has returned high, so a line held low yields no further characters.
- R8: A low pulse on `rxd` that ends before the middle of the start bit is rejected: it produces no `rxValid`, and the character that follows is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rateSel | input | 2 | Baud-rate switch setting |
| rxd | input | 1 | Serial receive line (asynchronous) |
| txd | output | 1 | Serial transmit line |
| txData | input | 8 | Byte to transmit |
| txValid | input | 1 | Transmit byte is offered |
| txReady | output | 1 | Transmitter idle, byte will be taken |
| rxData | output | 8 | Last received byte |
| rxValid | output | 1 | One-cycle pulse: new received byte |
| rxParErr | output | 1 | Parity error on the byte flagged by rxValid |
| rxFrameErr | output | 1 | Stop bit sampled low on that byte |

## Verification
The transmit start bit appears on `txd` at the same clock edge that takes the handshake. The bench finds that falling edge and then samples each bit cell half a cell later, plus whole cells, with cell length 16 times the divisor it computes itself. The start cell can be short by up to one divisor, so these sample points stay well inside every cell. `rxValid` comes one clock after the stop-bit midpoint, roughly ten and a half bit times after the start edge plus two synchronizer cycles. The bench therefore waits for it inside a bounded window of twelve bit times, and it checks that no extra pulse appears for two further bit times after a glitch or a framing error.

// File: rtl/ser8e1_pkg.sv
package ser8e1_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_WAIT
  } rxState_t;

  // control-to-datapath strobes, each one cycle wide
  typedef struct packed {
    logic rxShift;   // sample a data bit into the receive shifter
    logic rxPar;     // sample the parity bit
    logic rxDone;    // sample the stop bit and publish the character
    logic txLoad;    // load a new frame into the transmit shifter
    logic txShift;   // advance the transmit shifter by one bit
  } serStrobes_t;

endpackage

// File: rtl/ser8e1_baud.sv
module ser8e1_baud #(
  parameter int CLK_HZ = 200_000_000,
  parameter int OVS    = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] rateSel,
  output logic       tick
);

  function automatic int calcDiv(input int baud);
    int d;
    d = (CLK_HZ + (OVS * baud) / 2) / (OVS * baud);
    if (d < 1) d = 1;
    return d;
  endfunction

  localparam int DIV_SLOW0 = calcDiv(9600);
  localparam int DIV_SLOW1 = calcDiv(19200);
  localparam int DIV_FAST0 = calcDiv(57600);
  localparam int DIV_FAST1 = calcDiv(115200);
  localparam int CNT_W     = $clog2(DIV_SLOW0 + 1);

  logic [CNT_W-1:0] divCnt;
  logic [CNT_W-1:0] curDiv;

  always_comb begin
    case (rateSel)
      2'd0:    curDiv = CNT_W'(DIV_SLOW0);
      2'd1:    curDiv = CNT_W'(DIV_SLOW1);
      2'd2:    curDiv = CNT_W'(DIV_FAST0);
      default: curDiv = CNT_W'(DIV_FAST1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt <= '0;
      tick   <= 1'b0;
    end else if (divCnt >= curDiv - CNT_W'(1)) begin
      divCnt <= '0;
      tick   <= 1'b1;
    end else begin
      divCnt <= divCnt + CNT_W'(1);
      tick   <= 1'b0;
    end
  end

  // ticks are spaced by the selected divisor while the switch setting holds
  p_tick_spacing_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && curDiv > CNT_W'(1)) |=> (!tick || $changed(rateSel)));

endmodule

// File: rtl/ser8e1_ctrl.sv
module ser8e1_ctrl
  import ser8e1_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        rxS,
  input  logic        txValid,
  output logic        txReady,
  output serStrobes_t strb
);

  localparam int OVS_W      = $clog2(OVS);
  localparam int HALF       = OVS / 2 - 1;
  localparam int IDX_W      = $clog2(DATA_W);
  localparam int FRAME_BITS = DATA_W + 3;
  localparam int TXI_W      = $clog2(FRAME_BITS);

  rxState_t          rxState;
  logic [OVS_W-1:0]  rxCnt;
  logic [IDX_W-1:0]  rxBit;
  logic              rxCellEnd;

  logic              txBusy;
  logic [OVS_W-1:0]  txCnt;
  logic [TXI_W-1:0]  txIdx;
  logic              txCellEnd;

  assign rxCellEnd = tick && (rxCnt == OVS_W'(OVS - 1));
  assign txCellEnd = tick && (txCnt == OVS_W'(OVS - 1));
  assign txReady   = !txBusy;

  always_comb begin
    strb         = '0;
    strb.rxShift = (rxState == RX_DATA) && rxCellEnd;
    strb.rxPar   = (rxState == RX_PAR)  && rxCellEnd;
    strb.rxDone  = (rxState == RX_STOP) && rxCellEnd;
    strb.txLoad  = !txBusy && txValid;
    strb.txShift = txBusy && txCellEnd;
  end

  // receive sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      rxState <= RX_IDLE;
      rxCnt   <= '0;
      rxBit   <= '0;
    end else begin
      case (rxState)
        RX_IDLE: begin
          if (!rxS) begin
            rxState <= RX_START;
            rxCnt   <= '0;
          end
        end
        RX_START: begin
          if (tick) begin
            if (rxCnt == OVS_W'(HALF)) begin
              rxCnt <= '0;
              rxBit <= '0;
              rxState <= rxS ? RX_IDLE : RX_DATA;
            end else begin
              rxCnt <= rxCnt + OVS_W'(1);
            end
          end
        end
        RX_DATA: begin
          if (rxCellEnd) begin
            rxCnt <= '0;
            if (rxBit == IDX_W'(DATA_W - 1)) rxState <= RX_PAR;
            else rxBit <= rxBit + IDX_W'(1);
          end else if (tick) begin
            rxCnt <= rxCnt + OVS_W'(1);
          end
        end
        RX_PAR: begin
          if (rxCellEnd) begin
            rxCnt   <= '0;
            rxState <= RX_STOP;
          end else if (tick) begin
            rxCnt <= rxCnt + OVS_W'(1);
          end
        end
        RX_STOP: begin
          if (rxCellEnd) begin
            rxCnt   <= '0;
            rxState <= rxS ? RX_IDLE : RX_WAIT;
          end else if (tick) begin
            rxCnt <= rxCnt + OVS_W'(1);
          end
        end
        RX_WAIT: begin
          if (rxS) rxState <= RX_IDLE;
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  // transmit sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      txBusy <= 1'b0;
      txCnt  <= '0;
      txIdx  <= '0;
    end else if (!txBusy) begin
      if (txValid) begin
        txBusy <= 1'b1;
        txCnt  <= '0;
        txIdx  <= '0;
      end
    end else if (txCellEnd) begin
      txCnt <= '0;
      if (txIdx == TXI_W'(FRAME_BITS - 1)) txBusy <= 1'b0;
      else txIdx <= txIdx + TXI_W'(1);
    end else if (tick) begin
      txCnt <= txCnt + OVS_W'(1);
    end
  end

  p_accept_drops_ready_r4: assert property (@(posedge clk) disable iff (rst)
    (txValid && txReady) |=> !txReady);

endmodule

// File: rtl/ser8e1_path.sv
module ser8e1_path
  import ser8e1_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxd,
  input  serStrobes_t       strb,
  input  logic [DATA_W-1:0] txData,
  output logic              rxS,
  output logic              txd,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxParErr,
  output logic              rxFrameErr
);

  localparam int FRAME_BITS = DATA_W + 3;

  logic                  rxMeta;
  logic [DATA_W-1:0]     rxSreg;
  logic                  rxParBit;
  logic [FRAME_BITS-1:0] txFrame;

  // two-flop synchronizer, idles high
  always_ff @(posedge clk) begin
    if (rst) begin
      rxMeta <= 1'b1;
      rxS    <= 1'b1;
    end else begin
      rxMeta <= rxd;
      rxS    <= rxMeta;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxSreg     <= '0;
      rxParBit   <= 1'b0;
      rxData     <= '0;
      rxValid    <= 1'b0;
      rxParErr   <= 1'b0;
      rxFrameErr <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (strb.rxShift) rxSreg <= {rxS, rxSreg[DATA_W-1:1]};
      if (strb.rxPar) rxParBit <= rxS;
      if (strb.rxDone) begin
        rxValid    <= 1'b1;
        rxData     <= rxSreg;
        rxParErr   <= ^{rxSreg, rxParBit};
        rxFrameErr <= !rxS;
      end
    end
  end

  // frame register: bit 0 drives the line; stop, parity, data, start
  always_ff @(posedge clk) begin
    if (rst) begin
      txFrame <= '1;
    end else if (strb.txLoad) begin
      txFrame <= {1'b1, ^txData, txData, 1'b0};
    end else if (strb.txShift) begin
      txFrame <= {1'b1, txFrame[FRAME_BITS-1:1]};
    end
  end

  assign txd = txFrame[0];

  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    rxValid |=> !rxValid);

endmodule

// File: rtl/ser8e1_port.sv
module ser8e1_port
  import ser8e1_pkg::*;
#(
  parameter int CLK_HZ = 200_000_000,
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        rateSel,
  input  logic              rxd,
  output logic              txd,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxParErr,
  output logic              rxFrameErr
);

  logic        tick;
  logic        rxS;
  serStrobes_t strb;

  ser8e1_baud #(.CLK_HZ(CLK_HZ), .OVS(OVS)) i_baud (
    .clk(clk), .rst(rst), .rateSel(rateSel), .tick(tick)
  );

  ser8e1_ctrl #(.OVS(OVS), .DATA_W(DATA_W)) i_ctrl (
    .clk(clk), .rst(rst), .tick(tick), .rxS(rxS),
    .txValid(txValid), .txReady(txReady), .strb(strb)
  );

  ser8e1_path #(.DATA_W(DATA_W)) i_path (
    .clk(clk), .rst(rst), .rxd(rxd), .strb(strb), .txData(txData),
    .rxS(rxS), .txd(txd), .rxData(rxData), .rxValid(rxValid),
    .rxParErr(rxParErr), .rxFrameErr(rxFrameErr)
  );

  // idle transmitter keeps the line at the stop level
  p_idle_line_r2: assert property (@(posedge clk) disable iff (rst)
    txReady |-> txd);

endmodule

// File: tb/test_ser8e1_port.sv
module test_ser8e1_port;

  localparam int CLK = 3_686_400;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] rateSel = 2'd3;
  logic       loopOn = 1'b0;
  logic       drv = 1'b1;
  logic       rxd;
  logic       txd;
  logic [7:0] txData = 8'h00;
  logic       txValid = 1'b0;
  logic       txReady;
  logic [7:0] rxData;
  logic       rxValid;
  logic       rxParErr;
  logic       rxFrameErr;

  int errs = 0;
  int checks = 0;
  int gotCnt = 0;
  logic [7:0] gData = 8'h00;
  logic gPar = 1'b0;
  logic gFrm = 1'b0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign rxd = loopOn ? txd : drv;

  ser8e1_port #(.CLK_HZ(CLK)) i_ser8e1_port (
    .clk(clk), .rst(rst), .rateSel(rateSel), .rxd(rxd), .txd(txd),
    .txData(txData), .txValid(txValid), .txReady(txReady),
    .rxData(rxData), .rxValid(rxValid), .rxParErr(rxParErr),
    .rxFrameErr(rxFrameErr)
  );

  always @(negedge clk) begin
    if (!rst && rxValid) begin
      gotCnt = gotCnt + 1;
      gData  = rxData;
      gPar   = rxParErr;
      gFrm   = rxFrameErr;
    end
  end

  function automatic int expDiv(input int sel);
    int baud;
    int d;
    case (sel)
      0: baud = 9600;
      1: baud = 19200;
      2: baud = 57600;
      default: baud = 115200;
    endcase
    d = (CLK + 8 * baud) / (16 * baud);
    return (d < 1) ? 1 : d;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendTx(input logic [7:0] d);
    @(negedge clk);
    txData  = d;
    txValid = 1'b1;
    while (!txReady) @(negedge clk);
    @(negedge clk);
    txValid = 1'b0;
  endtask

  task automatic waitRx(input int prev, input int limit);
    int w;
    w = 0;
    while (gotCnt == prev && w < limit) begin
      @(negedge clk);
      w++;
    end
  endtask

  task automatic monitorTx(input logic [7:0] d, input int bt, input string req);
    logic [10:0] seen;
    logic [10:0] expw;
    int w;
    seen = '0;
    w = 0;
    while (txd && w < 20 * bt) begin
      @(negedge clk);
      w++;
    end
    repeat (bt / 2) @(negedge clk);
    for (int k = 0; k < 11; k++) begin
      seen[k] = txd;
      if (k == 5) check(txReady == 1'b0, "R4 busy mid-frame", int'(txReady), 0);
      if (k < 10) repeat (bt) @(negedge clk);
    end
    expw = {1'b1, ^d, d, 1'b0};
    check(seen == expw, req, int'(seen), int'(expw));
    w = 0;
    while (!txReady && w < bt) begin
      @(negedge clk);
      w++;
    end
    check(txReady == 1'b1, "R4 ready after stop", int'(txReady), 1);
  endtask

  task automatic driveChar(input logic [7:0] d, input bit badPar, input bit badStop, input int bt);
    logic [10:0] f;
    f = {~badStop, (^d) ^ badPar, d, 1'b0};
    for (int k = 0; k < 11; k++) begin
      @(negedge clk);
      drv = f[k];
      repeat (bt - 1) @(negedge clk);
    end
    if (badStop) repeat (3 * bt) @(negedge clk);
    @(negedge clk);
    drv = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int bt;
    int prev;
    logic [7:0] v;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(txd == 1'b1, "R1 txd", int'(txd), 1);
    check(txReady == 1'b1, "R1 txReady", int'(txReady), 1);
    check(rxValid == 1'b0 && gotCnt == 0, "R1 rxValid", gotCnt, 0);

    // R2/R3: every rate, line decoded at the computed bit time, looped back
    loopOn = 1'b1;
    for (int r = 0; r < 4; r++) begin
      rateSel = 2'(r);
      bt = 16 * expDiv(r);
      repeat (4) @(negedge clk);
      v = 8'h35 + 8'(r * 8'h4B);
      prev = gotCnt;
      sendTx(v);
      monitorTx(v, bt, "R2/R3 frame bits at selected rate");
      waitRx(prev, 12 * bt);
      check(gotCnt == prev + 1 && gData == v, "R5 loopback at rate", int'(gData), int'(v));
    end

    // R5/R6 exhaustive byte sweep through loopback at 115200
    rateSel = 2'd3;
    bt = 16 * expDiv(3);
    for (int b = 0; b < 256; b++) begin
      prev = gotCnt;
      sendTx(8'(b));
      waitRx(prev, 12 * bt);
      check(gotCnt == prev + 1 && gData == 8'(b), "R5 sweep data", int'(gData), b);
      check(gPar == 1'b0 && gFrm == 1'b0, "R6 sweep clean flags", int'({gPar, gFrm}), 0);
    end
    repeat (2 * bt) @(negedge clk);

    // receive-side error cases, bench drives the line
    loopOn = 1'b0;
    drv = 1'b1;
    repeat (bt) @(negedge clk);

    prev = gotCnt;
    driveChar(8'h5C, 1'b1, 1'b0, bt);
    waitRx(prev, 4 * bt);
    check(gPar == 1'b1, "R6 bad parity flagged", int'(gPar), 1);
    check(gData == 8'h5C && gFrm == 1'b0, "R6 data kept", int'(gData), 8'h5C);

    prev = gotCnt;
    driveChar(8'h5D, 1'b0, 1'b0, bt);
    waitRx(prev, 4 * bt);
    check(gotCnt == prev + 1 && gPar == 1'b0, "R6 good parity clear", int'(gPar), 0);

    prev = gotCnt;
    driveChar(8'hC3, 1'b0, 1'b1, bt);
    repeat (2 * bt) @(negedge clk);
    check(gotCnt == prev + 1, "R7 one char while line low", gotCnt - prev, 1);
    check(gFrm == 1'b1 && gData == 8'hC3, "R7 framing flagged", int'({gFrm, gData}), 9'h1C3);

    prev = gotCnt;
    driveChar(8'h3C, 1'b0, 1'b0, bt);
    waitRx(prev, 4 * bt);
    check(gotCnt == prev + 1 && gFrm == 1'b0 && gData == 8'h3C, "R7 recovery", int'(gData), 8'h3C);

    // R8 short start glitch (2 ticks) is rejected
    prev = gotCnt;
    @(negedge clk);
    drv = 1'b0;
    repeat (bt / 8) @(negedge clk);
    drv = 1'b1;
    repeat (2 * bt) @(negedge clk);
    check(gotCnt == prev, "R8 glitch ignored", gotCnt - prev, 0);
    driveChar(8'h81, 1'b0, 1'b0, bt);
    waitRx(prev, 4 * bt);
    check(gotCnt == prev + 1 && gData == 8'h81 && gPar == 1'b0, "R8 next char intact", int'(gData), 8'h81);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule